// File: doc/BRIEF.md
# Host-to-Narrow Peripheral Bus Width Adapter

This block sits between a 32-bit host data port and a set of I/O sub-areas whose devices may be 8 or 16 bits wide. A single host access to a sub-area becomes a short run of narrow bus cycles. On a write, each cycle carries one slice of the host word. On a read, each cycle delivers one slice, and the block packs the slices back into a full 32-bit word. For every narrow cycle the block drives a 2-bit sub-word address. Narrow data always travels on a fixed lane of the external data bus that does not start at bit zero: bits 15:8 for byte devices and bits 23:8 for halfword devices.

A configuration input carries a 2-bit width setting for each sub-area. A sub-area set to full width gets one 32-bit cycle with the sub-word address at zero. The host raises a request for one cycle and is then held busy. When the last narrow cycle completes, the block raises a one-cycle done pulse together with the assembled read word. Each narrow cycle lasts until the external ready input is sampled high.

Top module: `nbc_bridge`

## Requirements
- R1: After reset, host_busy, host_done, ext_cyc, ext_we, ext_sel, ext_sub, ext_addr, ext_dout and host_rdata are all zero.
- R2: The width of sub-area a is set by cfg_mode[2a+1:2a]: 00 means full 32-bit, 01 means byte, 10 means halfword, and the reserved code 11 behaves like 00. The setting is sampled when the request is accepted, so a change during an access has no effect on that access.
- R3: An access takes exactly 4 narrow cycles in byte mode, 2 in halfword mode and 1 in full-width mode.
- R4: ext_sub runs 00, 01, 10, 11 in byte mode and 00, 10 in halfword mode, always in ascending order. It stays 00 in full-width mode and whenever no cycle is active.
- R5: On a byte-mode write, cycle k drives host byte k (bits 8k+7:8k) on ext_dout[15:8]; every other ext_dout bit is 0. On any read, ext_dout is all zero.
- R6: On a halfword-mode write, cycle k drives host halfword k on ext_dout[23:8] with all other bits 0. A full-width write drives the whole host word on ext_dout[31:0].
- R7: On a byte-mode read, ext_din[15:8] sampled in cycle k becomes bits 8k+7:8k of host_rdata. All other ext_din bits are ignored.
- R8: On a halfword-mode read, ext_din[23:8] sampled in cycle k becomes host_rdata bits 16k+15:16k. A full-width read returns ext_din[31:0].
- R9: While ext_cyc is high and ext_rdy is low, the cycle is held: ext_cyc, ext_sub, ext_sel, ext_addr and ext_dout do not change.
- R10: host_busy is high from the cycle after a request is accepted until the last narrow cycle completes. host_done pulses for exactly one cycle right after that, with host_rdata valid. A request raised while busy is ignored, and a write leaves host_rdata unchanged.
- R11: During an access, ext_sel is the one-hot code of the requested sub-area, ext_addr holds the host address and ext_we holds the host direction. ext_sel is zero when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2*N_AREA | Per-sub-area width setting |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_area | input | AREA_W | Target sub-area |
| host_addr | input | ADDR_W | Word address inside the sub-area |
| host_wdata | input | HOST_W | Write word |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | HOST_W | Assembled read word |
| ext_cyc | output | 1 | External cycle strobe |
| ext_we | output | 1 | External write strobe |
| ext_sel | output | N_AREA | One-hot sub-area select |
| ext_addr | output | ADDR_W | External word address |
| ext_sub | output | 2 | Sub-word address bits |
| ext_dout | output | EXT_W | External write data |
| ext_din | input | EXT_W | External read data |
| ext_rdy | input | 1 | Narrow cycle completes when high |

## Verification
The hardest conditions to reach are the ones that occur inside an access already in progress: a second request, or a change to the width setting, arriving after the first narrow cycle has started and before the last one completes. The directed access task can inject either event at the first beat, while ready is held low. It then counts the narrow cycles that actually follow, and checks that the select lines and sub-word addresses keep the values that applied when the request was accepted. The read device model drives distinct filler values on every lane outside the active one. This exposes any slice taken from the wrong lane.

// File: rtl/nbc_pkg.sv
`timescale 1ns/1ps
package nbc_pkg;

   typedef enum logic [1:0] {
      NW_WIDE = 2'b00,
      NW_BYTE = 2'b01,
      NW_HALF = 2'b10,
      NW_RSVD = 2'b11
   } nw_mode_e;

   // index of the final narrow cycle for a width setting
   function automatic logic [1:0] nw_last_beat(nw_mode_e m);
      case (m)
         NW_BYTE: return 2'd3;
         NW_HALF: return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   // sub-word address presented during a given beat
   function automatic logic [1:0] nw_sub_addr(nw_mode_e m, logic [1:0] b);
      case (m)
         NW_BYTE: return b;
         NW_HALF: return {b[0], 1'b0};
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/nbc_seq.sv
`timescale 1ns/1ps
module nbc_seq
   import nbc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  nw_mode_e mode,
   input  logic     ext_rdy,
   output logic     active,
   output logic [1:0] beat,
   output logic     fire,
   output logic     fire_last,
   output logic     done
);

   assign fire      = active && ext_rdy;
   assign fire_last = fire && (beat == nw_last_beat(mode));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= 2'd0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               beat   <= 2'd0;
            end
         end else if (fire) begin
            if (fire_last) begin
               active <= 1'b0;
               beat   <= 2'd0;
               done   <= 1'b1;
            end else begin
               beat <= beat + 2'd1;
            end
         end
      end
   end

endmodule

// File: rtl/nbc_lanes.sv
`timescale 1ns/1ps
module nbc_lanes
   import nbc_pkg::*;
#(
   parameter int HOST_W  = 32,
   parameter int EXT_W   = 32,
   parameter int LANE_LO = 8
)(
   input  nw_mode_e           mode,
   input  logic [1:0]         beat,
   input  logic [HOST_W-1:0]  wdata,
   input  logic [EXT_W-1:0]   rd_bus,
   input  logic [HOST_W-1:0]  asm_q,
   output logic [EXT_W-1:0]   wr_bus,
   output logic [HOST_W-1:0]  merged
);

   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

   logic [4:0] byte_off;
   logic [4:0] half_off;

   assign byte_off = {beat, 3'b000};
   assign half_off = {beat[0], 4'b0000};

   always_comb begin
      wr_bus = '0;
      merged = asm_q;
      case (mode)
         NW_BYTE: begin
            wr_bus[LANE_LO +: BYTE_W] = wdata[byte_off +: BYTE_W];
            merged[byte_off +: BYTE_W] = rd_bus[LANE_LO +: BYTE_W];
         end
         NW_HALF: begin
            wr_bus[LANE_LO +: HALF_W] = wdata[half_off +: HALF_W];
            merged[half_off +: HALF_W] = rd_bus[LANE_LO +: HALF_W];
         end
         default: begin
            wr_bus[HOST_W-1:0] = wdata;
            merged             = rd_bus[HOST_W-1:0];
         end
      endcase
   end

endmodule

// File: rtl/nbc_bridge.sv
`timescale 1ns/1ps
module nbc_bridge
   import nbc_pkg::*;
#(
   parameter int ADDR_W  = 22,
   parameter int N_AREA  = 4,
   parameter int AREA_W  = $clog2(N_AREA),
   parameter int HOST_W  = 32,
   parameter int EXT_W   = 32,
   parameter int LANE_LO = 8
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*N_AREA-1:0]   cfg_mode,
   input  logic                  host_req,
   input  logic                  host_we,
   input  logic [AREA_W-1:0]     host_area,
   input  logic [ADDR_W-1:0]     host_addr,
   input  logic [HOST_W-1:0]     host_wdata,
   output logic                  host_busy,
   output logic                  host_done,
   output logic [HOST_W-1:0]     host_rdata,
   output logic                  ext_cyc,
   output logic                  ext_we,
   output logic [N_AREA-1:0]     ext_sel,
   output logic [ADDR_W-1:0]     ext_addr,
   output logic [1:0]            ext_sub,
   output logic [EXT_W-1:0]      ext_dout,
   input  logic [EXT_W-1:0]      ext_din,
   input  logic                  ext_rdy
);

   localparam int MODE_BITS = 2;

   if (HOST_W != 32) begin : g_err_host
      $error("nbc_bridge: HOST_W must be 32");
   end
   if (EXT_W < HOST_W) begin : g_err_ext
      $error("nbc_bridge: EXT_W must cover the host word");
   end
   if (LANE_LO + 16 > EXT_W) begin : g_err_lane
      $error("nbc_bridge: narrow lane exceeds external bus");
   end
   if (N_AREA < 2 || (1 << AREA_W) != N_AREA) begin : g_err_area
      $error("nbc_bridge: N_AREA must be a power of two, AREA_W its log2");
   end

   logic [MODE_BITS-1:0] area_mode [N_AREA];
   nw_mode_e             raw_mode;
   nw_mode_e             req_mode;
   nw_mode_e             mode_q;
   logic                 we_q;
   logic [AREA_W-1:0]    area_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [HOST_W-1:0]    wdata_q;
   logic [HOST_W-1:0]    asm_q;
   logic [HOST_W-1:0]    rdata_q;
   logic [HOST_W-1:0]    merged;
   logic [EXT_W-1:0]     wr_bus;
   logic                 active;
   logic [1:0]           beat;
   logic                 fire;
   logic                 fire_last;
   logic                 done;
   logic                 accept;

   for (genvar a = 0; a < N_AREA; a++) begin : g_area
      assign area_mode[a] = cfg_mode[MODE_BITS*a +: MODE_BITS];
      assign ext_sel[a]   = active && (area_q == AREA_W'(a));
   end

   assign raw_mode = nw_mode_e'(area_mode[host_area]);
   assign req_mode = (raw_mode == NW_RSVD) ? NW_WIDE : raw_mode;
   assign accept   = host_req && !active;

   nbc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .mode      (mode_q),
      .ext_rdy   (ext_rdy),
      .active    (active),
      .beat      (beat),
      .fire      (fire),
      .fire_last (fire_last),
      .done      (done)
   );

   nbc_lanes #(
      .HOST_W  (HOST_W),
      .EXT_W   (EXT_W),
      .LANE_LO (LANE_LO)
   ) u_lanes (
      .mode   (mode_q),
      .beat   (beat),
      .wdata  (wdata_q),
      .rd_bus (ext_din),
      .asm_q  (asm_q),
      .wr_bus (wr_bus),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         area_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         mode_q  <= NW_WIDE;
         asm_q   <= '0;
         rdata_q <= '0;
      end else if (accept) begin
         we_q    <= host_we;
         area_q  <= host_area;
         addr_q  <= host_addr;
         wdata_q <= host_wdata;
         mode_q  <= req_mode;
         asm_q   <= '0;
      end else if (fire && !we_q) begin
         asm_q <= merged;
         if (fire_last) begin
            rdata_q <= merged;
         end
      end
   end

   assign host_busy  = active;
   assign host_done  = done;
   assign host_rdata = rdata_q;
   assign ext_cyc    = active;
   assign ext_we     = active && we_q;
   assign ext_addr   = addr_q;
   assign ext_sub    = active ? nw_sub_addr(mode_q, beat) : 2'b00;
   assign ext_dout   = (active && we_q) ? wr_bus : '0;

endmodule

// File: rtl/nbc_bridge_chk.sv
`timescale 1ns/1ps
module nbc_bridge_chk #(
   parameter int ADDR_W  = 22,
   parameter int N_AREA  = 4,
   parameter int EXT_W   = 32,
   parameter int LANE_LO = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              host_busy,
   input logic              host_done,
   input logic              ext_cyc,
   input logic              ext_we,
   input logic              ext_rdy,
   input logic [N_AREA-1:0] ext_sel,
   input logic [ADDR_W-1:0] ext_addr,
   input logic [1:0]        ext_sub,
   input logic [EXT_W-1:0]  ext_dout
);

   localparam logic [EXT_W-1:0] BYTE_MASK = EXT_W'(8'hFF) << LANE_LO;

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (!ext_cyc && !host_busy && !host_done && ext_sel == '0)
            else $error("R1 outputs not idle during reset");
      end
   end

   p_first_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_cyc) |-> ext_sub == 2'b00);

   p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && !ext_rdy) |=> (ext_cyc && $stable(ext_sub) && $stable(ext_dout)
                                 && $stable(ext_addr) && $stable(ext_sel)));

   p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && ext_we && ext_sub[0]) |-> ((ext_dout & ~BYTE_MASK) == '0));

   p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cyc |-> $countones(ext_sel) == 1);

   p_sel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cyc |-> ext_sel == '0);

   p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> (!ext_cyc && !host_busy && $past(ext_cyc)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |=> !host_done);

endmodule

bind nbc_bridge nbc_bridge_chk #(
   .ADDR_W  (ADDR_W),
   .N_AREA  (N_AREA),
   .EXT_W   (EXT_W),
   .LANE_LO (LANE_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_busy (host_busy),
   .host_done (host_done),
   .ext_cyc   (ext_cyc),
   .ext_we    (ext_we),
   .ext_rdy   (ext_rdy),
   .ext_sel   (ext_sel),
   .ext_addr  (ext_addr),
   .ext_sub   (ext_sub),
   .ext_dout  (ext_dout)
);

// File: tb/nbc_bridge_tb_top.sv
`timescale 1ns/1ps
module nbc_bridge_tb_top;

   localparam int ADDR_W = 22;
   localparam int N_AREA = 4;
   localparam int AREA_W = 2;
   localparam int EXT_W  = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [7:0]         cfg_mode = 8'h00;
   logic               host_req = 1'b0;
   logic               host_we = 1'b0;
   logic [AREA_W-1:0]  host_area = '0;
   logic [ADDR_W-1:0]  host_addr = '0;
   logic [31:0]        host_wdata = '0;
   logic               host_busy;
   logic               host_done;
   logic [31:0]        host_rdata;
   logic               ext_cyc;
   logic               ext_we;
   logic [N_AREA-1:0]  ext_sel;
   logic [ADDR_W-1:0]  ext_addr;
   logic [1:0]         ext_sub;
   logic [EXT_W-1:0]   ext_dout;
   logic [EXT_W-1:0]   ext_din = '0;
   logic               ext_rdy = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   nbc_bridge dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_mode   (cfg_mode),
      .host_req   (host_req),
      .host_we    (host_we),
      .host_area  (host_area),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_busy  (host_busy),
      .host_done  (host_done),
      .host_rdata (host_rdata),
      .ext_cyc    (ext_cyc),
      .ext_we     (ext_we),
      .ext_sel    (ext_sel),
      .ext_addr   (ext_addr),
      .ext_sub    (ext_sub),
      .ext_dout   (ext_dout),
      .ext_din    (ext_din),
      .ext_rdy    (ext_rdy)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // m: 0 full width, 1 byte, 2 halfword
   function automatic int beats_for(int m);
      return (m == 1) ? 4 : (m == 2) ? 2 : 1;
   endfunction

   function automatic logic [1:0] sub_for(int m, int k);
      return (m == 1) ? 2'(k) : (m == 2) ? 2'(2 * k) : 2'b00;
   endfunction

   function automatic logic [31:0] dout_for(int m, int k, logic [31:0] w);
      if (m == 1) return {16'h0, w[8*k +: 8], 8'h0};
      if (m == 2) return {8'h0, w[16*k +: 16], 8'h0};
      return w;
   endfunction

   function automatic logic [31:0] din_for(int m, int k, logic [31:0] w);
      if (m == 1) return {16'hC3E1, w[8*k +: 8], 8'h97};
      if (m == 2) return {8'h5A, w[16*k +: 16], 8'hA6};
      return w;
   endfunction

   task automatic do_access(input int m, input bit we, input logic [1:0] area,
                            input logic [21:0] addr, input logic [31:0] word,
                            input int waits, input bit poke, input bit flip,
                            input string tag);
      int k;
      logic [31:0] rd_before;
      logic [7:0]  cfg_save;
      logic [1:0]  sub_hold;
      logic [31:0] dout_hold;
      rd_before = host_rdata;
      cfg_save  = cfg_mode;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_area = area;
      host_addr = addr; host_wdata = word;
      @(negedge clk);
      host_req = 1'b0; host_wdata = '0;
      k = 0;
      while (ext_cyc && k < 8) begin
         chk(host_busy == 1'b1, {tag, " R10 busy during access"}, 64'(host_busy), 64'd1);
         chk(ext_sel == 4'(1 << area), {tag, " R11 select"}, 64'(ext_sel), 64'(1 << area));
         chk(ext_addr == addr && ext_we == we, {tag, " R11 addr/we"},
             64'({ext_we, ext_addr}), 64'({we, addr}));
         chk(ext_sub == sub_for(m, k), {tag, " R4 sub address"}, 64'(ext_sub),
             64'(sub_for(m, k)));
         if (we)
            chk(ext_dout == dout_for(m, k, word), {tag, " R5 R6 write lane"},
                64'(ext_dout), 64'(dout_for(m, k, word)));
         else
            chk(ext_dout == '0, {tag, " R5 read drives zero"}, 64'(ext_dout), 64'd0);
         if (k == 0 && poke) begin
            host_req = 1'b1; host_area = area ^ 2'b01; host_we = ~we;
            @(negedge clk);
            host_req = 1'b0;
            chk(ext_cyc && ext_sel == 4'(1 << area), {tag, " R10 request while busy"},
                64'(ext_sel), 64'(1 << area));
         end
         if (k == 0 && flip) cfg_mode = ~cfg_mode;
         sub_hold = ext_sub; dout_hold = ext_dout;
         for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            chk(ext_cyc && ext_sub == sub_hold && ext_dout == dout_hold,
                {tag, " R9 hold during wait"}, 64'({ext_cyc, ext_sub, ext_dout}),
                64'({1'b1, sub_hold, dout_hold}));
         end
         ext_din = din_for(m, k, word);
         ext_rdy = 1'b1;
         @(negedge clk);
         ext_rdy = 1'b0;
         ext_din = 32'hDEAD_BEEF;
         k++;
      end
      chk(k == beats_for(m), {tag, " R3 beat count"}, 64'(k), 64'(beats_for(m)));
      chk(host_done && !host_busy, {tag, " R10 done pulse"},
          64'({host_done, host_busy}), 64'b10);
      if (we)
         chk(host_rdata == rd_before, {tag, " R10 write keeps rdata"},
             64'(host_rdata), 64'(rd_before));
      else
         chk(host_rdata == word, {tag, " R7 R8 read assembly"}, 64'(host_rdata), 64'(word));
      @(negedge clk);
      chk(!host_done && !ext_cyc, {tag, " R10 single done, no new cycle"},
          64'({host_done, ext_cyc}), 64'd0);
      cfg_mode = cfg_save;
   endtask

   task automatic t_reset();
      chk(!host_busy && !host_done && !ext_cyc && !ext_we, "R1 control idle",
          64'({host_busy, host_done, ext_cyc, ext_we}), 64'd0);
      chk(ext_sel == '0 && ext_sub == '0 && ext_addr == '0, "R1 ext address idle",
          64'({ext_sel, ext_sub, ext_addr}), 64'd0);
      chk(ext_dout == '0 && host_rdata == '0, "R1 data zero",
          64'({ext_dout, host_rdata}), 64'd0);
   endtask

   task automatic t_byte();
      cfg_mode = 8'b00_00_01_01;   // areas 0,1 byte
      do_access(1, 1'b1, 2'd1, 22'h12345, 32'hA1B2C3D4, 0, 1'b0, 1'b0, "byte write");
      do_access(1, 1'b0, 2'd0, 22'h00F0F, 32'h0F1E2D3C, 2, 1'b0, 1'b0, "byte read R7");
   endtask

   task automatic t_half();
      cfg_mode = 8'b10_10_00_00;   // areas 2,3 halfword
      do_access(2, 1'b1, 2'd3, 22'h3FFFF, 32'h8765_4321, 1, 1'b0, 1'b0, "half write R6");
      do_access(2, 1'b0, 2'd2, 22'h00001, 32'hCAFE_F00D, 0, 1'b0, 1'b0, "half read R8");
   endtask

   task automatic t_wide();
      cfg_mode = 8'b11_00_01_10;   // area 2 full width, area 3 reserved
      do_access(0, 1'b1, 2'd2, 22'h2AAAA, 32'h1357_9BDF, 0, 1'b0, 1'b0, "wide write R2");
      do_access(0, 1'b0, 2'd3, 22'h15555, 32'h2468_ACE0, 1, 1'b0, 1'b0, "reserved read R2");
   endtask

   task automatic t_corner();
      cfg_mode = 8'b01_10_01_10;
      do_access(1, 1'b0, 2'd1, 22'h00ABC, 32'h5566_7788, 0, 1'b1, 1'b0, "busy poke R10");
      do_access(2, 1'b1, 2'd2, 22'h00DEF, 32'h99AA_BBCC, 0, 1'b0, 1'b1, "cfg flip R2");
      do_access(1, 1'b1, 2'd3, 22'h00123, 32'h0102_0304, 3, 1'b0, 1'b1, "cfg flip byte R2");
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte();
      t_half();
      t_wide();
      t_corner();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule